// File: doc/BRIEF.md
# JTAG-to-Wishbone Single-Cycle Bus Master

This block lets a JTAG data register run single read and write cycles on a 32-bit pipelined Wishbone bus. The TAP controller lives outside. It hands the block decoded strobes for capture, shift and update, two select lines that pick one of two data registers, and TDI. The block returns TDO. One register holds a command: a direction flag and an address. The other holds a data word together with a completion flag.

Each update of the command register flips a request toggle in the TCK domain. A synchronizer carries the toggle into the system clock domain, where an edge detector turns it into one start event. A small master state machine then raises CYC and STB. It keeps STB, WE, address and write data steady until the slave acknowledges, and it honours STALL. When the cycle ends, the master stores the read data and flips a completion toggle. That toggle crosses back to TCK, so a later capture of the data register returns the read word with its flag set.

JTAG cannot insert wait states. Software therefore shifts the data register and checks the low bit before it trusts the data or issues the next command.

Top module: `jtag_wb_bridge`

## Requirements
- R1: The command register is 33 bits wide. Bit 0 is the direction (1 = write, 0 = read) and bits 32:1 are the byte address. TDI enters at the top bit on each shift and the register moves toward bit 0. TDO always shows bit 0 of the selected register. A capture of the command register loads the command currently held.
- R2: The data register is 33 bits wide. A capture loads bit 0 with the completion flag and bits 32:1 with the last read word. An update latches bits 32:1 as the write data for later write cycles.
- R3: Each update of the command register starts exactly one bus cycle. CYC and STB rise together, SEL is all ones, and ADR and WE come from the held command.
- R4: Once raised, STB and CYC stay high until ACK is sampled high. They are both low after that clock edge.
- R5: WE, ADR and DAT_W do not change while STB is high. A write cycle drives the latched write data on DAT_W.
- R6: While STALL is high, the request stays on the bus unchanged. An ACK that arrives before the request was accepted does not end the cycle.
- R7: On a read, the value on DAT_R at the acknowledging edge is returned in bits 32:1 of the next data register capture.
- R8: The completion flag is 1 after reset. It reads 0 from a command update until that cycle's end has crossed back to the TCK domain, and 1 after that.
- R9: An ACK seen while no cycle is open is ignored. No cycle starts, and the returned read data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| tck_rst_n | input | 1 | Asynchronous active-low reset for the TCK domain |
| dr_sel_cmd | input | 1 | Command register selected by the current instruction |
| dr_sel_data | input | 1 | Data register selected by the current instruction |
| dr_capture | input | 1 | Capture-DR strobe from the TAP |
| dr_shift | input | 1 | Shift-DR strobe from the TAP |
| dr_update | input | 1 | Update-DR strobe from the TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the selected register |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for the system domain |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Request strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | 32 | Byte address |
| wb_dat_w | output | 32 | Write data |
| wb_sel | output | 4 | Byte selects, all ones |
| wb_dat_r | input | 32 | Read data from the slave |
| wb_ack | input | 1 | Acknowledge from the slave |
| wb_stall | input | 1 | Slave not ready to accept the request |

## Verification
The bench builds the bridge with its defaults: 32-bit address and data, stall handling enabled, and two synchronizer stages. The system clock runs at 4 ns and TCK at 12 ns, so TCK is one third of the system clock. With stall handling on, the slave model can hold STALL for 0 to 2 cycles and delay ACK by 0 to 5 cycles on every transfer. This exercises STB held through long waits, the request kept frozen under stall, and a completion flag that is still 0 at an early capture. A spurious ACK is injected while the bus is idle to show it is ignored.

// File: rtl/jtag_wb_pkg.sv
package jtag_wb_pkg;
  typedef enum logic [0:0] {
    MST_IDLE = 1'b0,
    MST_BUS  = 1'b1
  } mst_state_e;
endpackage

// File: rtl/jtag_wb_sync.sv
module jtag_wb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/jtag_wb_tap_regs.sv
module jtag_wb_tap_regs #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          tck,
  input  logic          rst_n,
  input  logic          sel_cmd,
  input  logic          sel_data,
  input  logic          capture,
  input  logic          shift,
  input  logic          update,
  input  logic          tdi,
  output logic          tdo,
  input  logic          done_tgl_s,
  input  logic [DW-1:0] rd_word,
  output logic          req_tgl,
  output logic          hold_we,
  output logic [AW-1:0] hold_adr,
  output logic [DW-1:0] hold_wdata
);
  localparam int CW = AW + 1;
  localparam int DRW = DW + 1;

  logic [CW-1:0]  cmd_sh_q, cmd_sh_d;
  logic [DRW-1:0] dat_sh_q, dat_sh_d;
  logic [CW-1:0]  cmd_hold_q, cmd_hold_d;
  logic [DW-1:0]  wdat_q, wdat_d;
  logic           req_q, req_d;
  logic           done;

  assign done = (done_tgl_s == req_q);

  always_comb begin
    cmd_sh_d   = cmd_sh_q;
    dat_sh_d   = dat_sh_q;
    cmd_hold_d = cmd_hold_q;
    wdat_d     = wdat_q;
    req_d      = req_q;
    if (sel_cmd) begin
      if (capture)     cmd_sh_d = cmd_hold_q;
      else if (shift)  cmd_sh_d = {tdi, cmd_sh_q[CW-1:1]};
      else if (update) begin
        cmd_hold_d = cmd_sh_q;
        req_d      = ~req_q;
      end
    end
    if (sel_data) begin
      if (capture)     dat_sh_d = {rd_word, done};
      else if (shift)  dat_sh_d = {tdi, dat_sh_q[DRW-1:1]};
      else if (update) wdat_d   = dat_sh_q[DRW-1:1];
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      cmd_sh_q   <= '0;
      dat_sh_q   <= '0;
      cmd_hold_q <= '0;
      wdat_q     <= '0;
      req_q      <= 1'b0;
    end else begin
      cmd_sh_q   <= cmd_sh_d;
      dat_sh_q   <= dat_sh_d;
      cmd_hold_q <= cmd_hold_d;
      wdat_q     <= wdat_d;
      req_q      <= req_d;
    end
  end

  assign tdo        = sel_cmd ? cmd_sh_q[0] : dat_sh_q[0];
  assign req_tgl    = req_q;
  assign hold_we    = cmd_hold_q[0];
  assign hold_adr   = cmd_hold_q[CW-1:1];
  assign hold_wdata = wdat_q;
endmodule

// File: rtl/jtag_wb_master.sv
module jtag_wb_master
  import jtag_wb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit USE_STALL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s,
  input  logic          hold_we,
  input  logic [AW-1:0] hold_adr,
  input  logic [DW-1:0] hold_wdata,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [AW-1:0] wb_adr,
  output logic [DW-1:0] wb_dat_w,
  input  logic [DW-1:0] wb_dat_r,
  input  logic          wb_ack,
  input  logic          wb_stall,
  output logic [DW-1:0] rd_word,
  output logic          done_tgl
);
  mst_state_e    state_q, state_d;
  logic          req_prev_q;
  logic          start;
  logic          stall_eff;
  logic          acc_q, acc_d;
  logic          finish;
  logic          we_q, we_d;
  logic [AW-1:0] adr_q, adr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic [DW-1:0] rd_q, rd_d;
  logic          dt_q, dt_d;

  assign start     = req_s ^ req_prev_q;
  assign stall_eff = USE_STALL ? wb_stall : 1'b0;
  assign finish    = (state_q == MST_BUS) && wb_ack && (acc_q || !stall_eff);

  always_comb begin
    state_d = state_q;
    acc_d   = acc_q;
    we_d    = we_q;
    adr_d   = adr_q;
    wd_d    = wd_q;
    rd_d    = rd_q;
    dt_d    = dt_q;
    case (state_q)
      MST_IDLE: begin
        if (start) begin
          state_d = MST_BUS;
          acc_d   = 1'b0;
          we_d    = hold_we;
          adr_d   = hold_adr;
          wd_d    = hold_wdata;
        end
      end
      MST_BUS: begin
        if (!stall_eff) acc_d = 1'b1;
        if (finish) begin
          state_d = MST_IDLE;
          if (!we_q) rd_d = wb_dat_r;
          dt_d = ~dt_q;
        end
      end
      default: state_d = MST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= MST_IDLE;
      req_prev_q <= 1'b0;
      acc_q      <= 1'b0;
      we_q       <= 1'b0;
      adr_q      <= '0;
      wd_q       <= '0;
      rd_q       <= '0;
      dt_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      req_prev_q <= req_s;
      acc_q      <= acc_d;
      we_q       <= we_d;
      adr_q      <= adr_d;
      wd_q       <= wd_d;
      rd_q       <= rd_d;
      dt_q       <= dt_d;
    end
  end

  assign wb_cyc   = (state_q == MST_BUS);
  assign wb_stb   = (state_q == MST_BUS);
  assign wb_we    = we_q;
  assign wb_adr   = adr_q;
  assign wb_dat_w = wd_q;
  assign rd_word  = rd_q;
  assign done_tgl = dt_q;
endmodule

// File: rtl/jtag_wb_bridge.sv
module jtag_wb_bridge #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter bit USE_STALL = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic          tck,
  input  logic          tck_rst_n,
  input  logic          dr_sel_cmd,
  input  logic          dr_sel_data,
  input  logic          dr_capture,
  input  logic          dr_shift,
  input  logic          dr_update,
  input  logic          tdi,
  output logic          tdo,
  input  logic          clk,
  input  logic          rst_n,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [AW-1:0] wb_adr,
  output logic [DW-1:0] wb_dat_w,
  output logic [DW/8-1:0] wb_sel,
  input  logic [DW-1:0] wb_dat_r,
  input  logic          wb_ack,
  input  logic          wb_stall
);
  localparam int SEL_W = DW / 8;

  logic          sys_rst_n, tck_rst_s_n;
  logic          req_tgl, req_s;
  logic          done_tgl, done_s;
  logic          hold_we;
  logic [AW-1:0] hold_adr;
  logic [DW-1:0] hold_wdata;
  logic [DW-1:0] rd_word;

  jtag_wb_sync #(.STAGES(SYNC_STAGES)) u_rst_sys (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(sys_rst_n));
  jtag_wb_sync #(.STAGES(SYNC_STAGES)) u_rst_tck (
    .clk(tck), .rst_n(tck_rst_n), .d(1'b1), .q(tck_rst_s_n));

  jtag_wb_tap_regs #(.AW(AW), .DW(DW)) u_regs (
    .tck(tck), .rst_n(tck_rst_s_n),
    .sel_cmd(dr_sel_cmd), .sel_data(dr_sel_data),
    .capture(dr_capture), .shift(dr_shift), .update(dr_update),
    .tdi(tdi), .tdo(tdo),
    .done_tgl_s(done_s), .rd_word(rd_word),
    .req_tgl(req_tgl), .hold_we(hold_we),
    .hold_adr(hold_adr), .hold_wdata(hold_wdata));

  jtag_wb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(sys_rst_n), .d(req_tgl), .q(req_s));
  jtag_wb_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(tck), .rst_n(tck_rst_s_n), .d(done_tgl), .q(done_s));

  jtag_wb_master #(.AW(AW), .DW(DW), .USE_STALL(USE_STALL)) u_mst (
    .clk(clk), .rst_n(sys_rst_n), .req_s(req_s),
    .hold_we(hold_we), .hold_adr(hold_adr), .hold_wdata(hold_wdata),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r),
    .wb_ack(wb_ack), .wb_stall(wb_stall),
    .rd_word(rd_word), .done_tgl(done_tgl));

  assign wb_sel = {SEL_W{1'b1}};
endmodule

// File: rtl/jtag_wb_bridge_chk.sv
module jtag_wb_bridge_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wb_cyc,
  input logic            wb_stb,
  input logic            wb_we,
  input logic [AW-1:0]   wb_adr,
  input logic [DW-1:0]   wb_dat_w,
  input logic [DW/8-1:0] wb_sel,
  input logic            wb_ack,
  input logic            wb_stall
);
  // R3
  cyc_stb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc == wb_stb);
  // R3
  sel_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb |-> wb_sel == {(DW/8){1'b1}});
  // R4
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb && !wb_ack |=> wb_stb);
  // R5
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb && !wb_ack |=> $stable(wb_we) && $stable(wb_adr) && $stable(wb_dat_w));
  // R6
  stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb && wb_stall && !wb_ack |=> wb_stb && $stable(wb_adr) && $stable(wb_we));
endmodule

bind jtag_wb_bridge jtag_wb_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
  .wb_we(wb_we), .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_sel(wb_sel),
  .wb_ack(wb_ack), .wb_stall(wb_stall));

// File: tb/jtag_wb_bridge_tb_top.sv
`timescale 1ns/1ps
module jtag_wb_bridge_tb_top;
  logic clk = 1'b0, tck = 1'b0, rst_n = 1'b0;
  logic sel_cmd = 0, sel_data = 0, cap = 0, shf = 0, upd = 0, tdi = 0;
  logic tdo;
  logic cyc, stb, we, ack, slv_ack, stall, spur_ack = 0;
  logic [31:0] adr, dat_w, dat_r;
  logic [3:0] sel;

  always #2 clk = ~clk;
  always #6 tck = ~tck;

  jtag_wb_bridge dut_i (
    .tck(tck), .tck_rst_n(rst_n), .dr_sel_cmd(sel_cmd), .dr_sel_data(sel_data),
    .dr_capture(cap), .dr_shift(shf), .dr_update(upd), .tdi(tdi), .tdo(tdo),
    .clk(clk), .rst_n(rst_n), .wb_cyc(cyc), .wb_stb(stb), .wb_we(we),
    .wb_adr(adr), .wb_dat_w(dat_w), .wb_sel(sel), .wb_dat_r(dat_r),
    .wb_ack(ack), .wb_stall(stall));

  assign ack = slv_ack | spur_ack;

  // slave memory model
  logic [31:0] mem [16];
  int unsigned cfg_stall = 0, cfg_dly = 0;
  int unsigned scnt, dcnt;
  logic active;
  logic [31:0] log_adr, log_dat;
  logic log_we;
  logic [3:0] log_sel;
  assign stall = cyc && stb && (!active ? (cfg_stall != 0) : (scnt != 0));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slv_ack <= 0; active <= 0; scnt <= 0; dcnt <= 0; dat_r <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= 0;
    end else begin
      slv_ack <= 0;
      if (cyc && stb && !slv_ack) begin
        if (!active) begin active <= 1; scnt <= cfg_stall; dcnt <= cfg_dly; end
        else if (scnt != 0) scnt <= scnt - 1;
        else if (dcnt != 0) dcnt <= dcnt - 1;
        else begin
          slv_ack <= 1; active <= 0;
          log_adr <= adr; log_we <= we; log_dat <= dat_w; log_sel <= sel;
          if (we) mem[adr[5:2]] <= dat_w;
          else dat_r <= mem[adr[5:2]];
        end
      end
    end
  end

  // bus monitor
  int cyc_starts = 0, mon_err4 = 0, mon_err6 = 0;
  logic p_stb = 0, p_ack = 0, p_stall = 0, p_cyc = 0;
  logic [31:0] p_adr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc && !p_cyc) cyc_starts++;
      if (p_stb && !p_ack && !stb) mon_err4++;
      if (p_stb && p_ack && stb) mon_err4++;
      if (p_stb && p_stall && !p_ack && (!stb || adr != p_adr)) mon_err6++;
    end
    p_stb = stb; p_ack = ack; p_stall = stall; p_cyc = cyc; p_adr = adr;
  end

  int n_chk = 0, n_bad = 0;
  logic [31:0] shadow [16];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic jtag_dr(input bit is_cmd, input logic [32:0] din, output logic [32:0] dout);
    @(negedge tck); sel_cmd = is_cmd; sel_data = !is_cmd; cap = 1;
    @(negedge tck); cap = 0; shf = 1;
    for (int i = 0; i < 33; i++) begin
      tdi = din[i]; #1; dout[i] = tdo;
      @(negedge tck);
    end
    shf = 0; upd = 1;
    @(negedge tck); upd = 0; sel_cmd = 0; sel_data = 0;
  endtask

  task automatic poll(output bit done, output logic [31:0] rd, output bit first_done);
    logic [32:0] o;
    done = 0;
    for (int k = 0; k < 40 && !done; k++) begin
      jtag_dr(0, 33'h0, o);
      if (k == 0) first_done = o[0];
      done = o[0]; rd = o[32:1];
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, output bit fd);
    logic [32:0] o; bit dn; logic [31:0] rd;
    jtag_dr(0, {d, 1'b0}, o);
    jtag_dr(1, {a, 1'b1}, o);
    poll(dn, rd, fd);
    check(dn, "R8 write completes", {63'b0, dn}, 1);
    check(log_we == 1 && log_adr == a, "R3 write address/direction", {log_we, log_adr}, {1'b1, a});
    check(log_dat == d, "R5 write data", log_dat, d);
    shadow[a[5:2]] = d;
  endtask

  task automatic do_read(input logic [31:0] a, output bit fd, output logic [31:0] rd);
    logic [32:0] o; bit dn;
    jtag_dr(1, {a, 1'b0}, o);
    poll(dn, rd, fd);
    check(dn, "R8 read completes", {63'b0, dn}, 1);
    check(log_we == 0 && log_adr == a, "R3 read address/direction", {log_we, log_adr}, {1'b0, a});
    check(rd == shadow[a[5:2]], "R7 read data", rd, shadow[a[5:2]]);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [32:0] o; bit fd, dn; logic [31:0] rd; int starts0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) shadow[i] = 0;
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(!cyc && !stb, "R4 idle after reset", {cyc, stb}, 0);
    jtag_dr(0, 33'h0, o);
    check(o == 33'h1, "R8 done=1, zero data after reset (R2)", o, 33'h1);

    // directed: long stall and delay, early capture sees busy
    cfg_stall = 2; cfg_dly = 5;
    do_write(32'h0000_0010, 32'hA5A5_5A5A, fd);
    check(!fd, "R8 busy flag at early capture", {63'b0, fd}, 0);
    check(log_sel == 4'hF, "R3 byte selects", log_sel, 4'hF);
    do_read(32'h0000_0010, fd, rd);
    // command readback
    jtag_dr(1, {32'h0000_0010, 1'b0}, o);
    check(o == {32'h0000_0010, 1'b0}, "R1 command capture", o, {32'h0000_0010, 1'b0});
    poll(dn, rd, fd);
    check(rd == 32'hA5A5_5A5A, "R2 data capture after read", rd, 32'hA5A5_5A5A);

    // directed: zero latency
    cfg_stall = 0; cfg_dly = 0;
    do_write(32'h0000_003C, 32'h1234_5678, fd);
    do_read(32'h0000_003C, fd, rd);

    // R9: spurious ack while idle
    starts0 = cyc_starts;
    @(negedge clk); spur_ack = 1; repeat (2) @(negedge clk); spur_ack = 0;
    repeat (10) @(negedge clk);
    check(cyc_starts == starts0 && !cyc, "R9 no cycle from stray ack", cyc_starts, starts0);
    jtag_dr(0, 33'h0, o);
    check(o == {32'h1234_5678, 1'b1}, "R9 read data unchanged", o, {32'h1234_5678, 1'b1});

    // random mix
    for (int t = 0; t < 24; t++) begin
      logic [31:0] a;
      a = {$urandom, 2'b00} & 32'hFFFF_FFFC;
      a = {a[31:6], 4'($urandom_range(0, 3)), 2'b00};
      cfg_stall = $urandom_range(0, 2); cfg_dly = $urandom_range(0, 5);
      if ($urandom_range(0, 1) == 1) do_write(a, $urandom, fd);
      else do_read(a, fd, rd);
    end

    repeat (10) @(negedge clk);
    check(cyc_starts == 29, "R3 one bus cycle per command update", cyc_starts, 29);
    check(mon_err4 == 0, "R4 strobe held until ack", mon_err4, 0);
    check(mon_err6 == 0, "R6 request kept under stall", mon_err6, 0);
    finish_run();
  end
endmodule